// File: doc/BRIEF.md
# Wide Search Key Assembler

This block sits between a host command port and a ternary search engine. A host asks for a 288-bit search by issuing four back-to-back search cycles. Each cycle carries a 72-bit slice of the key on the data bus and a handful of control fields on an 11-bit command bus. The assembler gathers the four slices into one 288-bit key. It also collects the two mask-register-pair indices, the three upper result-address bits and the result-register index. It then presents everything as one request, qualified by a single-cycle valid strobe.

The meaning of the shared command bits changes from cycle to cycle, and the assembler decodes them by position in the sequence. A width flag in the first cycle tells a 288-bit search from a narrow one. A narrow search is refused with its own flag. A sequence that breaks off before its fourth word, or whose third cycle carries the wrong width flag, is dropped with an error pulse.

Top module: `wide_search_asm`

## Requirements
- R1: After reset `reqValid`, `seqError` and `narrowReject` are low, and the assembler is idle.
- R2: A search cycle is one with `cmdValid` high and `cmdBus[1:0]` equal to 2'b10. While idle, any other cycle produces no request and no flag.
- R3: The first captured word becomes `reqKey[287:216]`, the second `[215:144]`, the third `[143:72]` and the fourth `[71:0]`.
- R4: `reqMaskHi` is `{cmdBus[10], cmdBus[5:3]}` from the first cycle. `reqMaskLo` is the same field taken from the third cycle.
- R5: `reqAddrHi` is `cmdBus[8:6]` from the third cycle. `reqResultSel` is `cmdBus[8:6]` from the fourth cycle.
- R6: The following bits have no effect on the request: `cmdBus[9:6]` in the first cycle, `cmdBus[10:2]` in the second cycle, `cmdBus[9]` in the third cycle, and `cmdBus[10]` and `cmdBus[5:2]` in the fourth cycle.
- R7: `reqValid` is high for exactly one cycle, the cycle after the fourth word is captured. All request fields are valid during that cycle.
- R8: During the second, third or fourth cycle, a cycle that is not a search cycle aborts the sequence. `seqError` is then high for one cycle, in the following cycle. No request is produced, and the assembler returns to idle without treating the bad cycle as a new start.
- R9: A third cycle that is a search cycle but has `cmdBus[2]` = 1 aborts the sequence in the same way as R8.
- R10: A search cycle while idle with `cmdBus[2]` = 0 starts no sequence. Instead `narrowReject` is high for one cycle, in the following cycle.
- R11: A new first cycle may arrive in the same cycle that `reqValid` is high. Requests can therefore follow every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command qualifier |
| cmdBus | input | 11 | Command code and per-cycle fields |
| dataIn | input | 72 | Key slice for this cycle |
| reqValid | output | 1 | One-cycle strobe for an assembled request |
| reqKey | output | 288 | Assembled search key |
| reqMaskHi | output | 4 | Mask-pair index for key bits 287:144 |
| reqMaskLo | output | 4 | Mask-pair index for key bits 143:0 |
| reqAddrHi | output | 3 | Upper result-address bits driven on a hit |
| reqResultSel | output | 3 | Result register that stores the outcome |
| seqError | output | 1 | One-cycle pulse for an aborted sequence |
| narrowReject | output | 1 | One-cycle pulse for a refused narrow search |

## Verification
Two events can coincide. One is the valid strobe for a finished request. The other is the capture of the first word of the next sequence, which happens in the same cycle. The bench provokes this by issuing directed back-to-back sequences and many random ones with no gap between them. It judges the overlap two ways: the key and fields seen during the strobe must still belong to the finished request, and the following request must carry only the new words. A second overlap, an abort whose bad cycle looks like a valid first cycle, is checked by confirming that such a cycle never starts a request.

// File: rtl/wide_search_pkg.sv
package wide_search_pkg;
  localparam int NUM_WORDS = 4;
  localparam int CMD_W     = 11;
  localparam int IDX_W     = 4;
  localparam int SEL_W     = 3;
  localparam logic [1:0] CODE_SEARCH = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HAVE1 = 2'd1,
    ST_HAVE2 = 2'd2,
    ST_HAVE3 = 2'd3
  } seqStateT;

  typedef struct packed {
    logic [NUM_WORDS-1:0] loadWord;
  } strobeT;
endpackage

// File: rtl/wide_search_ctrl.sv
module wide_search_ctrl
  import wide_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdLow,
  output strobeT     strobes,
  output logic       reqValid,
  output logic       seqError,
  output logic       narrowReject
);
  seqStateT state, stateNext;
  logic isSearch;
  logic wideFlag;
  logic errNext, narrowNext, validNext;

  assign isSearch = cmdValid && (cmdLow[1:0] == CODE_SEARCH);
  assign wideFlag = cmdLow[2];

  always_comb begin
    stateNext = state;
    strobes = '0;
    errNext = 1'b0;
    narrowNext = 1'b0;
    validNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (isSearch) begin
          if (wideFlag) begin
            strobes.loadWord[0] = 1'b1;
            stateNext = ST_HAVE1;
          end else begin
            narrowNext = 1'b1;
          end
        end
      end
      ST_HAVE1: begin
        if (isSearch) begin
          strobes.loadWord[1] = 1'b1;
          stateNext = ST_HAVE2;
        end else begin
          errNext = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_HAVE2: begin
        if (isSearch && !wideFlag) begin
          strobes.loadWord[2] = 1'b1;
          stateNext = ST_HAVE3;
        end else begin
          errNext = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: begin
        if (isSearch) begin
          strobes.loadWord[3] = 1'b1;
          validNext = 1'b1;
        end else begin
          errNext = 1'b1;
        end
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      reqValid <= 1'b0;
      seqError <= 1'b0;
      narrowReject <= 1'b0;
    end else begin
      state <= stateNext;
      reqValid <= validNext;
      seqError <= errNext;
      narrowReject <= narrowNext;
    end
  end

  // R3: at most one key slice is loaded per cycle
  assert_one_slice_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.loadWord));

  // R7: a request only follows an accepted search cycle
  assert_req_after_search_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(isSearch));

  // R7: the strobe lasts a single cycle
  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R8: errors come only from a sequence in progress
  assert_error_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> ($past(state) != ST_IDLE));

  // R10: narrow refusal follows an idle search cycle with the width bit clear
  assert_narrow_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    narrowReject |-> ($past(isSearch) && !$past(wideFlag) && $past(state) == ST_IDLE));

  // R8: outcome flags never coincide
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({reqValid, seqError, narrowReject}) <= 1);
endmodule

// File: rtl/wide_search_dp.sv
module wide_search_dp
  import wide_search_pkg::*;
#(
  parameter int DATA_W = 72,
  localparam int KEY_W = DATA_W * NUM_WORDS
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  idxField,
  input  logic [SEL_W-1:0]  selField,
  output logic [KEY_W-1:0]  reqKey,
  output logic [IDX_W-1:0]  reqMaskHi,
  output logic [IDX_W-1:0]  reqMaskLo,
  output logic [SEL_W-1:0]  reqAddrHi,
  output logic [SEL_W-1:0]  reqResultSel
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : gSlice
    logic [DATA_W-1:0] sliceQ;
    always_ff @(posedge clk) begin
      if (!rstN) sliceQ <= '0;
      else if (strobes.loadWord[i]) sliceQ <= dataIn;
    end
    assign reqKey[(NUM_WORDS-1-i)*DATA_W +: DATA_W] = sliceQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqMaskHi <= '0;
      reqMaskLo <= '0;
      reqAddrHi <= '0;
      reqResultSel <= '0;
    end else begin
      if (strobes.loadWord[0]) reqMaskHi <= idxField;
      if (strobes.loadWord[2]) begin
        reqMaskLo <= idxField;
        reqAddrHi <= selField;
      end
      if (strobes.loadWord[3]) reqResultSel <= selField;
    end
  end

  // R3: the first slice lands in the top of the key
  assert_first_slice_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord[0] |=> reqKey[KEY_W-1 -: DATA_W] == $past(dataIn));

  // R3: the last slice lands in the bottom of the key
  assert_last_slice_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord[3] |=> reqKey[DATA_W-1:0] == $past(dataIn));

  // R4: the upper mask index is held while later slices arrive
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadWord[1] || strobes.loadWord[2] || strobes.loadWord[3]) |=> $stable(reqMaskHi));

  // R5: the result register index comes from the fourth cycle
  assert_sel_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord[3] |=> reqResultSel == $past(selField));
endmodule

// File: rtl/wide_search_asm.sv
module wide_search_asm
  import wide_search_pkg::*;
#(
  parameter int DATA_W = 72,
  localparam int KEY_W = DATA_W * NUM_WORDS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdBus,
  input  logic [DATA_W-1:0] dataIn,
  output logic              reqValid,
  output logic [KEY_W-1:0]  reqKey,
  output logic [IDX_W-1:0]  reqMaskHi,
  output logic [IDX_W-1:0]  reqMaskLo,
  output logic [SEL_W-1:0]  reqAddrHi,
  output logic [SEL_W-1:0]  reqResultSel,
  output logic              seqError,
  output logic              narrowReject
);
  strobeT strobes;
  logic [IDX_W-1:0] idxField;
  logic [SEL_W-1:0] selField;
  logic unusedCmdBit;

  assign idxField = {cmdBus[10], cmdBus[5:3]};
  assign selField = cmdBus[8:6];
  assign unusedCmdBit = cmdBus[9];

  wide_search_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .cmdValid(cmdValid),
    .cmdLow(cmdBus[2:0]),
    .strobes(strobes),
    .reqValid(reqValid),
    .seqError(seqError),
    .narrowReject(narrowReject)
  );

  wide_search_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .dataIn(dataIn),
    .idxField(idxField),
    .selField(selField),
    .reqKey(reqKey),
    .reqMaskHi(reqMaskHi),
    .reqMaskLo(reqMaskLo),
    .reqAddrHi(reqAddrHi),
    .reqResultSel(reqResultSel)
  );
endmodule

// File: tb/wide_search_asm_tb.sv
module wide_search_asm_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [10:0] cmdBus = '0;
  logic [71:0] dataIn = '0;
  logic reqValid, seqError, narrowReject;
  logic [287:0] reqKey;
  logic [3:0] reqMaskHi, reqMaskLo;
  logic [2:0] reqAddrHi, reqResultSel;

  always #5 clk = ~clk;

  wide_search_asm dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBus(cmdBus), .dataIn(dataIn),
    .reqValid(reqValid), .reqKey(reqKey), .reqMaskHi(reqMaskHi), .reqMaskLo(reqMaskLo),
    .reqAddrHi(reqAddrHi), .reqResultSel(reqResultSel),
    .seqError(seqError), .narrowReject(narrowReject)
  );

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  int mState = 0;
  logic [71:0] mWord[4];
  logic [3:0] mHi, mLo;
  logic [2:0] mAddr, mSel;
  bit expValid = 0, expErr = 0, expNarrow = 0;
  string errTag = "R8";
  string validTag = "R7";
  string quietTag = "R2";

  function automatic logic [287:0] expKey();
    return {mWord[0], mWord[1], mWord[2], mWord[3]};
  endfunction

  task automatic check(string tag, string what, logic [287:0] act, logic [287:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // sample results of the previous cycle, then drive one new cycle
  task automatic step(bit v, logic [1:0] code, logic [10:0] c, logic [71:0] d);
    bit isS;
    @(negedge clk);
    check(validTag, "reqValid", 288'(reqValid), 288'(expValid));
    check(errTag, "seqError", 288'(seqError), 288'(expErr));
    check(quietTag == "R2" ? "R10" : quietTag, "narrowReject", 288'(narrowReject), 288'(expNarrow));
    if (expValid) begin
      check("R3", "key", reqKey, expKey());
      check("R4", "maskHi", 288'(reqMaskHi), 288'(mHi));
      check("R4", "maskLo", 288'(reqMaskLo), 288'(mLo));
      check("R5", "addrHi", 288'(reqAddrHi), 288'(mAddr));
      check("R6", "resultSel", 288'(reqResultSel), 288'(mSel));
    end
    cmdValid = v;
    cmdBus = {c[10:2], code};
    dataIn = d;
    isS = v && (code == 2'b10);
    validTag = (expValid && isS && c[2] && mState == 0) ? "R11" : "R7";
    expValid = 0; expErr = 0; expNarrow = 0;
    errTag = "R8";
    quietTag = "R2";
    case (mState)
      0: if (isS) begin
           if (c[2]) begin
             mWord[0] = d; mHi = {c[10], c[5:3]}; mState = 1;
           end else begin
             expNarrow = 1; quietTag = "R10";
           end
         end
      1: if (isS) begin mWord[1] = d; mState = 2; end
         else begin expErr = 1; mState = 0; end
      2: if (isS && !c[2]) begin
           mWord[2] = d; mLo = {c[10], c[5:3]}; mAddr = c[8:6]; mState = 3;
         end else begin
           expErr = 1; mState = 0;
           if (isS) errTag = "R9";
         end
      default: begin
           if (isS) begin mWord[3] = d; mSel = c[8:6]; expValid = 1; end
           else expErr = 1;
           mState = 0;
         end
    endcase
  endtask

  function automatic logic [71:0] rndWord();
    return {$urandom, $urandom, $urandom};
  endfunction

  // one well-formed four-cycle sequence; junk fills the ignored bits
  task automatic wideSeq(logic [3:0] hi, logic [3:0] lo, logic [2:0] addr, logic [2:0] sel, logic [10:0] junk);
    step(1, 2'b10, {hi[3], junk[9:6], hi[2:0], 1'b1, 2'b00}, rndWord());
    step(1, 2'b10, {junk[10:3], 3'b000}, rndWord());
    step(1, 2'b10, {lo[3], junk[9], addr, lo[2:0], 1'b0, 2'b00}, rndWord());
    step(1, 2'b10, {junk[10], junk[9], sel, junk[5:2], 2'b00}, rndWord());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reqValid at reset", 288'(reqValid), 288'(0));
    check("R1", "seqError at reset", 288'(seqError), 288'(0));
    check("R1", "narrowReject at reset", 288'(narrowReject), 288'(0));
    rstN = 1'b1;
    // R2: idle noise, wrong codes and dropped valid
    step(0, 2'b10, 11'h7ff, rndWord());
    step(1, 2'b01, 11'h7fc, rndWord());
    step(1, 2'b11, 11'h004, rndWord());
    step(1, 2'b00, 11'h004, rndWord());
    // R3 R4 R5 R6: clean sequences with opposite junk
    wideSeq(4'hA, 4'h5, 3'h6, 3'h1, 11'h7ff);
    wideSeq(4'hA, 4'h5, 3'h6, 3'h1, 11'h000);
    // R11: back-to-back
    wideSeq(4'h3, 4'hC, 3'h2, 3'h7, 11'h2aa);
    wideSeq(4'hF, 4'h0, 3'h5, 3'h4, 11'h155);
    step(0, 2'b00, 11'h0, 72'h0);
    // R8: abort in second cycle; the bad cycle looks like nothing
    step(1, 2'b10, 11'h004, rndWord());
    step(0, 2'b10, 11'h004, rndWord());
    // R8: abort in fourth cycle by wrong code
    step(1, 2'b10, 11'h004, rndWord());
    step(1, 2'b10, 11'h000, rndWord());
    step(1, 2'b10, 11'h000, rndWord());
    step(1, 2'b11, 11'h000, rndWord());
    // R9: third cycle with width bit set
    step(1, 2'b10, 11'h004, rndWord());
    step(1, 2'b10, 11'h000, rndWord());
    step(1, 2'b10, 11'h004, rndWord());
    // R10: narrow search refused
    step(1, 2'b10, 11'h000, rndWord());
    step(1, 2'b10, 11'h7f8, rndWord());
    step(0, 2'b00, 11'h0, 72'h0);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit v;
      logic [1:0] code;
      logic [10:0] c;
      v = ($urandom % 12) != 0;
      code = (($urandom % 10) == 0) ? 2'($urandom) : 2'b10;
      c = 11'($urandom);
      if (mState == 0) c[2] = ($urandom % 6) != 0;
      else if (mState == 2) c[2] = ($urandom % 8) == 0;
      step(v, code, c, rndWord());
    end
    step(0, 2'b00, 11'h0, 72'h0);
    step(0, 2'b00, 11'h0, 72'h0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule